// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns an asynchronous serial line back into characters. It is driven by an oversampling tick at sixteen times the bit rate, supplied from outside. The receiver looks for a falling edge and confirms the start bit halfway through it. It then samples each following bit at its centre, least significant bit first, and checks the stop level. Each finished frame is presented as a 9-bit character word together with parity, framing and break indications, marked by a one-clock valid pulse.

A 3-bit format code selects how many bits follow the start bit and what they mean: plain bytes, 7-bit characters with parity, bytes with parity, 9-bit words, or bytes with an extra address-marker bit. A 2-bit code selects the stop length, which sets where the stop level is checked. Further controls select odd or even parity, route the local transmit output back into the receiver, and enable reception. Storage of received characters, the bit-rate generator and the transmitter sit outside this block.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, charValid, charData, parityErr, frameErr and breakDet are all 0.
- R2: A low level seen on a tick in idle starts a frame. It is re-sampled on the 8th tick after that. If it is high there, the frame is dropped and no character is produced.
- R3: Bits after the start bit are sampled every 16 ticks and placed least significant bit first. Each frame produces exactly one charValid pulse, one clock long.
- R4: Format 001 receives 8 data bits into charData[7:0], with charData[8]=0. The unused codes 000, 010 and 110 behave the same way.
- R5: Format 011 receives 7 data bits into charData[6:0], followed by a parity bit. charData[8:7]=0, and parityErr=1 when the parity bit is wrong.
- R6: Format 111 receives 8 data bits into charData[7:0], followed by a parity bit. charData[8]=0, and parityErr=1 when the parity bit is wrong.
- R7: Format 100 receives 9 data bits into charData[8:0].
- R8: Format 101 receives 8 data bits into charData[7:0]. The ninth received bit is delivered in charData[8] as an address marker.
- R9: With oddParity=0, a correct frame has an even count of ones over the data and parity bits. With oddParity=1, the count is odd.
- R10: parityErr reads 0 in every format that carries no parity bit (001, 100, 101 and the unused codes).
- R11: stopSel=00 (half bit) checks the stop level 12 ticks after the last bit sample. The codes 01 (one bit), 10 (one and a half bits) and 11 (two bits) check it 16 ticks after, at the centre of the first stop bit. A low level there sets frameErr.
- R12: A framing error in which every received bit is 0 is a break. breakDet=1 and charData=0 are reported, and no new frame starts until the line has returned high.
- R13: loopEn=1 feeds txLoop into the receiver and ignores rxLine. loopEn=0 does the reverse.
- R14: With rxEn=0, no frame is started and no character is produced. Reception resumes when rxEn is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock pulse at 16x the bit rate |
| rxLine | input | 1 | Serial receive line, idle high |
| txLoop | input | 1 | Local transmit output, used in loopback |
| loopEn | input | 1 | 1 selects txLoop as the receiver input |
| rxEn | input | 1 | Reception enable |
| frameMode | input | 3 | Frame format code |
| stopSel | input | 2 | Stop length code |
| oddParity | input | 1 | 1 selects odd parity, 0 even |
| charValid | output | 1 | One-clock pulse when a character is delivered |
| charData | output | 9 | Received character word |
| parityErr | output | 1 | Parity error of the delivered character |
| frameErr | output | 1 | Stop level was low at its check point |
| breakDet | output | 1 | Framing error with all bits zero |

## Verification
Bytes with a single set bit at either end separate correct bit ordering from reversed ordering. Each format is driven with correct and with inverted parity bits, under both parity senses. This distinguishes a wrong bit count, a wrong field mask and a wrong parity sense. A low stop level under the half-bit and two-bit codes, and a line held low for many bit times, distinguish a framing error from a break. They also show whether the receiver waits for the line to recover. A three-tick low pulse, a frame on the unselected line and a frame sent while reception is disabled must all produce nothing. Any character the reference queue does not expect is reported.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

  // Frame format codes
  localparam logic [2:0] FMT_8  = 3'b001;
  localparam logic [2:0] FMT_7P = 3'b011;
  localparam logic [2:0] FMT_9  = 3'b100;
  localparam logic [2:0] FMT_8W = 3'b101;
  localparam logic [2:0] FMT_8P = 3'b111;

  // Largest number of bits between start and stop
  localparam int FRAME_MAX = 9;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);

  // Strobes from control to datapath
  typedef struct packed {
    logic             clear;    // start bit confirmed, wipe collected bits
    logic             capture;  // sample line into bit slot bitIdx
    logic [IDX_W-1:0] bitIdx;
    logic             deliver;  // stop check point reached
  } rxStrobes_t;

  // Number of bits following the start bit for a format code
  function automatic logic [IDX_W-1:0] frameLen(input logic [2:0] mode);
    case (mode)
      FMT_7P:                 frameLen = IDX_W'(8);
      FMT_8P, FMT_9, FMT_8W:  frameLen = IDX_W'(9);
      default:                frameLen = IDX_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/urx_ctrl.sv
module urx_ctrl
  import uart_frame_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxEn,
  input  logic       lineBit,
  input  logic [2:0] mode,
  input  logic [1:0] stopSel,
  output rxStrobes_t strobes
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'((OVERSAMPLE * 3) / 4 - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_HOLD} rxState_t;

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] stopLast;
  logic [IDX_W-1:0] lastIdx;
  logic             startOk;
  logic             bitDone;
  logic             stopDone;

  assign stopLast = (stopSel == 2'b00) ? HALF_LAST : BIT_LAST;
  assign lastIdx  = frameLen(mode) - IDX_W'(1);

  assign startOk  = rxEn && tick && (state == ST_START) && (tickCnt == START_LAST) && !lineBit;
  assign bitDone  = rxEn && tick && (state == ST_DATA)  && (tickCnt == BIT_LAST);
  assign stopDone = rxEn && tick && (state == ST_STOP)  && (tickCnt == stopLast);

  always_comb begin
    strobes.clear   = startOk;
    strobes.capture = bitDone;
    strobes.bitIdx  = bitIdx;
    strobes.deliver = stopDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!rxEn) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tick && !lineBit) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == START_LAST) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= lineBit ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (tickCnt == BIT_LAST) begin
              tickCnt <= '0;
              if (bitIdx == lastIdx) begin
                state <= ST_STOP;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (tickCnt == stopLast) begin
              tickCnt <= '0;
              state   <= lineBit ? ST_IDLE : ST_HOLD;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (lineBit) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/urx_datapath.sv
module urx_datapath
  import uart_frame_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxLine,
  input  logic                 txLoop,
  input  logic                 loopEn,
  input  logic [2:0]           mode,
  input  logic                 oddParity,
  input  rxStrobes_t           strobes,
  output logic                 lineBit,
  output logic                 charValid,
  output logic [FRAME_MAX-1:0] charData,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 breakDet
);

  logic                   lineSel;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [FRAME_MAX-1:0]   frameBits;
  logic [FRAME_MAX-1:0]   payload;
  logic                   parityBad;
  logic                   allZero;

  assign lineSel = loopEn ? txLoop : rxLine;
  assign lineBit = syncQ[SYNC_STAGES-1];

  // Input synchronizer, idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], lineSel};
  end

  // Bit collection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameBits <= '0;
    end else if (strobes.clear) begin
      frameBits <= '0;
    end else if (strobes.capture && (strobes.bitIdx < IDX_W'(FRAME_MAX))) begin
      frameBits[strobes.bitIdx] <= lineBit;
    end
  end

  // Format-dependent unpacking and parity check
  always_comb begin
    payload   = '0;
    parityBad = 1'b0;
    case (mode)
      FMT_7P: begin
        payload   = {2'b00, frameBits[6:0]};
        parityBad = (^frameBits[7:0]) != oddParity;
      end
      FMT_8P: begin
        payload   = {1'b0, frameBits[7:0]};
        parityBad = (^frameBits[8:0]) != oddParity;
      end
      FMT_9, FMT_8W: begin
        payload = frameBits;
      end
      default: begin
        payload = {1'b0, frameBits[7:0]};
      end
    endcase
  end

  assign allZero = (frameBits == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      charValid <= 1'b0;
      charData  <= '0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
    end else begin
      charValid <= strobes.deliver;
      if (strobes.deliver) begin
        charData  <= payload;
        parityErr <= parityBad;
        frameErr  <= !lineBit;
        breakDet  <= !lineBit && allZero;
      end
    end
  end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxLine,
  input  logic       txLoop,
  input  logic       loopEn,
  input  logic       rxEn,
  input  logic [2:0] frameMode,
  input  logic [1:0] stopSel,
  input  logic       oddParity,
  output logic       charValid,
  output logic [8:0] charData,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakDet
);

  rxStrobes_t strobes;
  logic       lineBit;

  urx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .rxEn    (rxEn),
    .lineBit (lineBit),
    .mode    (frameMode),
    .stopSel (stopSel),
    .strobes (strobes)
  );

  urx_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxLine    (rxLine),
    .txLoop    (txLoop),
    .loopEn    (loopEn),
    .mode      (frameMode),
    .oddParity (oddParity),
    .strobes   (strobes),
    .lineBit   (lineBit),
    .charValid (charValid),
    .charData  (charData),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet)
  );

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxEn,
  input logic [2:0] frameMode,
  input logic       charValid,
  input logic [8:0] charData,
  input logic       parityErr,
  input logic       frameErr,
  input logic       breakDet
);

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charValid |=> !charValid);

  // R12
  break_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && breakDet) |-> (frameErr && (charData == 9'd0)));

  // R10
  parity_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && ($past(frameMode) != 3'b011) && ($past(frameMode) != 3'b111)) |-> !parityErr);

  // R5
  seven_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charValid && ($past(frameMode) == 3'b011)) |-> (charData[8:7] == 2'b00));

  // R14
  rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charValid |-> $past(rxEn));

endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rxEn      (rxEn),
  .frameMode (frameMode),
  .charValid (charValid),
  .charData  (charData),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .breakDet  (breakDet)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;

  localparam int CLK_PERIOD      = 10;
  localparam int TICK_DIV        = 4;
  localparam int OVERSAMPLE      = 16;
  localparam int BIT_CLKS        = TICK_DIV * OVERSAMPLE;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic       txLoop = 1'b1;
  logic       loopEn = 1'b0;
  logic       rxEn = 1'b0;
  logic [2:0] frameMode = 3'b001;
  logic [1:0] stopSel = 2'b01;
  logic       oddParity = 1'b0;
  logic       charValid;
  logic [8:0] charData;
  logic       parityErr;
  logic       frameErr;
  logic       breakDet;

  int          divCnt = 0;
  int          checkCount = 0;
  int          failCount = 0;
  bit          sendOnTx = 1'b0;
  string       curReq = "R1";
  logic [11:0] expQ[$];

  uart_frame_rx u_uart_frame_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .rxLine    (rxLine),
    .txLoop    (txLoop),
    .loopEn    (loopEn),
    .rxEn      (rxEn),
    .frameMode (frameMode),
    .stopSel   (stopSel),
    .oddParity (oddParity),
    .charValid (charValid),
    .charData  (charData),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (divCnt == TICK_DIV - 1) begin
      divCnt <= 0;
      tick16 <= 1'b1;
    end else begin
      divCnt <= divCnt + 1;
      tick16 <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  // Reference comparison on every clock: each delivered word must be the next expected one
  task automatic monitor();
    logic [11:0] got;
    logic [11:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && charValid) begin
        got = {breakDet, frameErr, parityErr, charData};
        if (expQ.size() == 0) begin
          check(1'b0, curReq, 16'(got), 16'h0, "unexpected character");
        end else begin
          exp = expQ.pop_front();
          check(got == exp, curReq, 16'(got), 16'(exp), "character {brk,fe,pe,data}");
        end
      end
    end
  endtask

  task automatic drive(input bit b, input int n);
    if (sendOnTx) txLoop = b;
    else          rxLine = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic checkDrained(input string what);
    check(expQ.size() == 0, curReq, 16'(expQ.size()), 16'h0, what);
  endtask

  task automatic sendFrame(input logic [2:0] mode, input logic [8:0] p, input bit badPar,
                           input bit badStop, input logic [1:0] stp, input bit expectOut);
    logic [8:0] bits;
    logic [8:0] data;
    int         n;
    bit         pe;
    bit         brk;
    int         stopClks;
    frameMode = mode;
    stopSel   = stp;
    bits = '0;
    pe   = 1'b0;
    case (mode)
      3'b011: begin
        n = 8; bits[6:0] = p[6:0];
        bits[7] = (^p[6:0]) ^ oddParity ^ badPar;
        data = {2'b00, p[6:0]}; pe = badPar;
      end
      3'b111: begin
        n = 9; bits[7:0] = p[7:0];
        bits[8] = (^p[7:0]) ^ oddParity ^ badPar;
        data = {1'b0, p[7:0]}; pe = badPar;
      end
      3'b100, 3'b101: begin
        n = 9; bits = p; data = p;
      end
      default: begin
        n = 8; bits[7:0] = p[7:0]; data = {1'b0, p[7:0]};
      end
    endcase
    brk = badStop && (bits == 9'd0);
    if (expectOut) expQ.push_back({brk, badStop, pe, data});
    case (stp)
      2'b00:   stopClks = BIT_CLKS / 2;
      2'b01:   stopClks = BIT_CLKS;
      2'b10:   stopClks = (BIT_CLKS * 3) / 2;
      default: stopClks = BIT_CLKS * 2;
    endcase
    drive(1'b0, BIT_CLKS);
    for (int i = 0; i < n; i++) drive(bits[i], BIT_CLKS);
    drive(!badStop, stopClks);
    drive(1'b1, 2 * BIT_CLKS);
    checkDrained("characters still pending after frame");
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failCount++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
        finishRun();
      end
    join_none

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    curReq = "R1";
    check(charValid == 1'b0, "R1", 16'(charValid), 16'h0, "charValid after reset");
    check(charData == 9'd0, "R1", 16'(charData), 16'h0, "charData after reset");
    check({parityErr, frameErr, breakDet} == 3'b000, "R1",
          16'({parityErr, frameErr, breakDet}), 16'h0, "flags after reset");

    rxEn = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R4 plain bytes and unused codes
    curReq = "R4";
    sendFrame(3'b001, 9'h0A5, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b001, 9'h03C, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b000, 9'h0C3, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b110, 9'h081, 1'b0, 1'b0, 2'b01, 1'b1);

    // R3 bit order, one pulse per frame
    curReq = "R3";
    sendFrame(3'b001, 9'h001, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b001, 9'h080, 1'b0, 1'b0, 2'b01, 1'b1);

    // R5 seven bits plus parity, even
    curReq = "R5";
    sendFrame(3'b011, 9'h055, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b011, 9'h07F, 1'b1, 1'b0, 2'b01, 1'b1);

    // R6 eight bits plus parity, even
    curReq = "R6";
    sendFrame(3'b111, 9'h0C7, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b111, 9'h0C7, 1'b1, 1'b0, 2'b01, 1'b1);

    // R9 odd parity sense
    curReq = "R9";
    oddParity = 1'b1;
    sendFrame(3'b011, 9'h02A, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b111, 9'h0F0, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b111, 9'h0F0, 1'b1, 1'b0, 2'b01, 1'b1);
    oddParity = 1'b0;

    // R7 nine data bits
    curReq = "R7";
    sendFrame(3'b100, 9'h1A5, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b100, 9'h05A, 1'b0, 1'b0, 2'b01, 1'b1);

    // R8 address marker
    curReq = "R8";
    sendFrame(3'b101, 9'h1F0, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b101, 9'h00F, 1'b0, 1'b0, 2'b01, 1'b1);

    // R10 no parity flag in formats without a parity bit
    curReq = "R10";
    sendFrame(3'b100, 9'h101, 1'b0, 1'b0, 2'b01, 1'b1);
    sendFrame(3'b001, 9'h007, 1'b0, 1'b0, 2'b01, 1'b1);
    oddParity = 1'b1;
    sendFrame(3'b101, 9'h003, 1'b0, 1'b0, 2'b01, 1'b1);
    oddParity = 1'b0;

    // R11 stop lengths and framing errors
    curReq = "R11";
    sendFrame(3'b001, 9'h0E1, 1'b0, 1'b0, 2'b00, 1'b1);
    sendFrame(3'b001, 9'h01E, 1'b0, 1'b0, 2'b10, 1'b1);
    sendFrame(3'b001, 9'h066, 1'b0, 1'b0, 2'b11, 1'b1);
    sendFrame(3'b001, 9'h099, 1'b0, 1'b1, 2'b00, 1'b1);
    sendFrame(3'b001, 9'h042, 1'b0, 1'b1, 2'b11, 1'b1);

    // R12 break: long low level gives one character, then recovery
    curReq = "R12";
    frameMode = 3'b001;
    stopSel   = 2'b01;
    expQ.push_back({1'b1, 1'b1, 1'b0, 9'h000});
    drive(1'b0, 12 * BIT_CLKS);
    drive(1'b1, 2 * BIT_CLKS);
    checkDrained("break character count");
    sendFrame(3'b001, 9'h05C, 1'b0, 1'b0, 2'b01, 1'b1);

    // R2 short low pulse is not a start bit
    curReq = "R2";
    drive(1'b0, 3 * TICK_DIV);
    drive(1'b1, 2 * BIT_CLKS);
    checkDrained("glitch produced a character");

    // R13 loopback path, rxLine held low and ignored
    curReq = "R13";
    loopEn = 1'b1;
    repeat (4) @(negedge clk);
    rxLine = 1'b0;
    sendOnTx = 1'b1;
    sendFrame(3'b001, 9'h0B4, 1'b0, 1'b0, 2'b01, 1'b1);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    loopEn = 1'b0;
    repeat (4) @(negedge clk);
    sendFrame(3'b001, 9'h02D, 1'b0, 1'b0, 2'b01, 1'b0);
    sendOnTx = 1'b0;

    // R14 reception disabled, then resumed
    curReq = "R14";
    rxEn = 1'b0;
    sendFrame(3'b001, 9'h0F3, 1'b0, 1'b0, 2'b01, 1'b0);
    rxEn = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(3'b001, 9'h03F, 1'b0, 1'b0, 2'b01, 1'b1);

    finishRun();
  end

endmodule